// File: doc/BRIEF.md
# Logic Analyzer Pattern Trigger Unit

This block decides when a multi-channel logic analyzer capture fires. A byte-wide configuration port programs a per-channel level pattern, an optional edge condition on one channel, a 16-bit trigger count and a 24-bit trigger-position address. The block watches a 32-bit sample bus that moves forward on a sample-enable strobe. It also watches a running 24-bit capture address supplied by the memory side.

After an arm pulse, every accepted sample is checked against the pattern and the edge condition. When the number of qualifying samples reaches the programmed count, the trigger flag rises. The capture address of the firing sample is latched and can be read back as three bytes. The flag holds until the next arm pulse. A don't-care output tells the capture side whether a trigger-position address was given.

Top module: `la_trig_unit`

## Requirements
- R1: After reset the trigger flag is 0, all nine condition registers read 0, the trigger count reads 1 (offset 0x0A = 0x01, 0x0B = 0x00), the position address reads 0, the latched address reads 0 and the don't-care output is 1.
- R2: Channel c takes its 2-bit level code from condition register c/4 (offsets 0x00..0x07), bits 2*(c mod 4)+1 : 2*(c mod 4). Code 01 requires the channel high, 10 requires it low, 00 leaves it free and 11 never matches. A sample qualifies on level only if every channel meets its code.
- R3: The edge register at offset 0x08 holds the edge kind in bits 7:6 (00 none, 01 rising, 10 falling, 11 either) and the channel index in bits 4:0. An edge is judged against the previous accepted sample, so the first accepted sample after an arm never satisfies an edge condition.
- R4: A sample is accepted only in a cycle with smp_en high, the block armed, the flag low and no arm pulse. The flag fires on the accepted qualifying sample that brings the hit count to the trigger count. A count of 0 behaves as 1.
- R5: The trigger count is written low byte at 0x0A and high byte at 0x0B, and both bytes read back.
- R6: The position address is written at 0x0C (bits 7:0), 0x0D (bits 15:8) and 0x0E (bits 23:16). pos_dont_care is 1 exactly when all 24 bits are zero.
- R7: In the cycle after the clock edge that accepts the firing sample, trig_flag is 1. At the same time the cap_addr value of that sample reads back at 0x10 (bits 7:0), 0x11 (bits 15:8) and 0x12 (bits 23:16).
- R8: Once set, the flag and the latched address hold until an arm pulse. An arm pulse clears the flag and the hit count. Samples before the first arm after reset are ignored.
- R9: With every level code 00 and edge kind 00, the first accepted sample after an arm fires when the count is 1.
- R10: Reads at unmapped offsets (0x09, 0x0F, 0x13 and above) return 0. Writes to them and to 0x10..0x12 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Register offset for writes and reads |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data for cfg_addr (combinational) |
| arm | input | 1 | Arm pulse; clears flag and hit count |
| smp_en | input | 1 | Sample-enable strobe |
| smp_data | input | 32 | Sample bus, one bit per channel |
| cap_addr | input | 24 | Running capture address |
| trig_flag | output | 1 | Sticky trigger flag |
| pos_dont_care | output | 1 | High when the position address is zero |

## Verification
The trigger flag and the latched address are registered. Both are due one edge after the firing sample, so the bench drives each sample at a falling edge and compares trig_flag 1 ns after the following rising edge. It does this for every step, against a model advanced by the same step. Register readback and pos_dont_care are combinational from the stored bytes. They are read after the write edge, with cfg_addr set at a falling edge and sampled 1 ns later. The latched address is read the same way once the model reports a fire.

// File: rtl/la_trig_pkg.sv
package la_trig_pkg;

  typedef enum logic [1:0] {
    LV_FREE  = 2'b00,
    LV_HIGH  = 2'b01,
    LV_LOW   = 2'b10,
    LV_NEVER = 2'b11
  } lvl_code_e;

  typedef enum logic [1:0] {
    EG_NONE = 2'b00,
    EG_RISE = 2'b01,
    EG_FALL = 2'b10,
    EG_ANY  = 2'b11
  } edge_kind_e;

  // level code test for one channel
  function automatic logic lvl_ok(input logic [1:0] code, input logic bit_v);
    case (lvl_code_e'(code))
      LV_FREE: lvl_ok = 1'b1;
      LV_HIGH: lvl_ok = bit_v;
      LV_LOW:  lvl_ok = ~bit_v;
      default: lvl_ok = 1'b0;
    endcase
  endfunction

  // transition test between previous and current value of one channel
  function automatic logic edge_ok(input logic [1:0] kind, input logic prv, input logic cur);
    case (edge_kind_e'(kind))
      EG_RISE: edge_ok = ~prv & cur;
      EG_FALL: edge_ok = prv & ~cur;
      EG_ANY:  edge_ok = prv ^ cur;
      default: edge_ok = 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/la_trig_regs.sv
module la_trig_regs #(
  parameter int NCH       = 32,
  parameter int CNT_BYTES = 2,
  parameter int POS_BYTES = 3,
  parameter int CAP_BYTES = 3,
  parameter int AW        = 5,
  localparam int IDXW     = $clog2(NCH)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic [AW-1:0]          cfg_addr,
  input  logic [7:0]             cfg_wdata,
  output logic [7:0]             cfg_rdata,
  input  logic [CAP_BYTES*8-1:0] cap_val,
  output logic [2*NCH-1:0]       lvl_flat,
  output logic [1:0]             edge_kind,
  output logic [IDXW-1:0]        edge_idx,
  output logic [CNT_BYTES*8-1:0] cnt_val,
  output logic                   pos_dont_care
);
  localparam int NLVL     = NCH / 4;
  localparam int EDGE_OFF = NLVL;
  localparam int CNT_OFF  = NLVL + 2;
  localparam int POS_OFF  = CNT_OFF + CNT_BYTES;
  localparam int CAP_OFF  = POS_OFF + POS_BYTES + 1;

  logic [7:0] lvl_q [NLVL];
  logic [7:0] edge_q;
  logic [7:0] cnt_q [CNT_BYTES];
  logic [7:0] pos_q [POS_BYTES];
  logic [POS_BYTES*8-1:0] pos_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NLVL; i++) lvl_q[i] <= '0;
      edge_q <= '0;
      for (int i = 0; i < CNT_BYTES; i++) cnt_q[i] <= (i == 0) ? 8'd1 : 8'd0;
      for (int i = 0; i < POS_BYTES; i++) pos_q[i] <= '0;
    end else if (cfg_we) begin
      for (int i = 0; i < NLVL; i++)
        if (cfg_addr == AW'(i)) lvl_q[i] <= cfg_wdata;
      if (cfg_addr == AW'(EDGE_OFF)) edge_q <= cfg_wdata;
      for (int i = 0; i < CNT_BYTES; i++)
        if (cfg_addr == AW'(CNT_OFF + i)) cnt_q[i] <= cfg_wdata;
      for (int i = 0; i < POS_BYTES; i++)
        if (cfg_addr == AW'(POS_OFF + i)) pos_q[i] <= cfg_wdata;
    end
  end

  genvar g;
  generate
    for (g = 0; g < NLVL; g++) begin : g_lvl
      assign lvl_flat[g*8 +: 8] = lvl_q[g];
    end
    for (g = 0; g < CNT_BYTES; g++) begin : g_cnt
      assign cnt_val[g*8 +: 8] = cnt_q[g];
    end
    for (g = 0; g < POS_BYTES; g++) begin : g_pos
      assign pos_val[g*8 +: 8] = pos_q[g];
    end
  endgenerate

  assign edge_kind     = edge_q[7:6];
  assign edge_idx      = edge_q[IDXW-1:0];
  assign pos_dont_care = (pos_val == '0);

  always_comb begin
    cfg_rdata = '0;
    for (int i = 0; i < NLVL; i++)
      if (cfg_addr == AW'(i)) cfg_rdata = lvl_q[i];
    if (cfg_addr == AW'(EDGE_OFF)) cfg_rdata = edge_q;
    for (int i = 0; i < CNT_BYTES; i++)
      if (cfg_addr == AW'(CNT_OFF + i)) cfg_rdata = cnt_q[i];
    for (int i = 0; i < POS_BYTES; i++)
      if (cfg_addr == AW'(POS_OFF + i)) cfg_rdata = pos_q[i];
    for (int i = 0; i < CAP_BYTES; i++)
      if (cfg_addr == AW'(CAP_OFF + i)) cfg_rdata = cap_val[i*8 +: 8];
  end

endmodule

// File: rtl/la_trig_match.sv
module la_trig_match
  import la_trig_pkg::*;
#(
  parameter int NCH   = 32,
  localparam int IDXW = $clog2(NCH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic             armed,
  input  logic             smp_en,
  input  logic [NCH-1:0]   smp_data,
  input  logic [2*NCH-1:0] lvl_flat,
  input  logic [1:0]       edge_kind,
  input  logic [IDXW-1:0]  edge_idx,
  output logic             level_hit,
  output logic             edge_hit,
  output logic             hit,
  output logic             prev_vld
);
  logic [NCH-1:0] ch_ok;
  logic [NCH-1:0] prev_q;
  logic           prev_vld_q;

  genvar c;
  generate
    for (c = 0; c < NCH; c++) begin : g_ch
      assign ch_ok[c] = lvl_ok(lvl_flat[2*c +: 2], smp_data[c]);
    end
  endgenerate

  assign level_hit = &ch_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q     <= '0;
      prev_vld_q <= 1'b0;
    end else if (arm) begin
      prev_vld_q <= 1'b0;
    end else if (smp_en && armed) begin
      prev_q     <= smp_data;
      prev_vld_q <= 1'b1;
    end
  end

  assign prev_vld = prev_vld_q;
  assign edge_hit = (edge_kind == EG_NONE) ||
                    (prev_vld_q && edge_ok(edge_kind, prev_q[edge_idx], smp_data[edge_idx]));
  assign hit      = level_hit & edge_hit;

endmodule

// File: rtl/la_trig_seq.sv
module la_trig_seq #(
  parameter int CNTW = 16,
  parameter int CAPW = 24
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            arm,
  input  logic            smp_en,
  input  logic            hit,
  input  logic [CNTW-1:0] cnt_val,
  input  logic [CAPW-1:0] cap_addr,
  output logic            armed,
  output logic            trig_flag,
  output logic            fire,
  output logic [CAPW-1:0] cap_q
);
  logic [CNTW-1:0] hits_q;
  logic            armed_q;
  logic            flag_q;
  logic [CNTW:0]   tgt;
  logic [CNTW:0]   nxt;
  logic            accept;

  assign tgt    = (cnt_val == '0) ? (CNTW+1)'(1) : {1'b0, cnt_val};
  assign nxt    = {1'b0, hits_q} + (CNTW+1)'(1);
  assign accept = smp_en & armed_q & ~flag_q & ~arm;
  assign fire   = accept & hit & (nxt >= tgt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hits_q  <= '0;
      armed_q <= 1'b0;
      flag_q  <= 1'b0;
      cap_q   <= '0;
    end else if (arm) begin
      hits_q  <= '0;
      armed_q <= 1'b1;
      flag_q  <= 1'b0;
    end else if (accept && hit) begin
      hits_q <= nxt[CNTW-1:0];
      if (fire) begin
        flag_q <= 1'b1;
        cap_q  <= cap_addr;
      end
    end
  end

  assign armed     = armed_q;
  assign trig_flag = flag_q;

endmodule

// File: rtl/la_trig_unit.sv
module la_trig_unit #(
  parameter int NCH       = 32,
  parameter int CNT_BYTES = 2,
  parameter int POS_BYTES = 3,
  parameter int CAP_BYTES = 3,
  parameter int AW        = 5,
  localparam int CNTW     = CNT_BYTES * 8,
  localparam int CAPW     = CAP_BYTES * 8,
  localparam int IDXW     = $clog2(NCH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [AW-1:0]   cfg_addr,
  input  logic [7:0]      cfg_wdata,
  output logic [7:0]      cfg_rdata,
  input  logic            arm,
  input  logic            smp_en,
  input  logic [NCH-1:0]  smp_data,
  input  logic [CAPW-1:0] cap_addr,
  output logic            trig_flag,
  output logic            pos_dont_care
);
  logic [2*NCH-1:0] lvl_flat;
  logic [1:0]       edge_kind;
  logic [IDXW-1:0]  edge_idx;
  logic [CNTW-1:0]  cnt_val;
  logic [CAPW-1:0]  cap_q;
  logic             armed_w;
  logic             fire_w;
  logic             hit_w;
  logic             level_hit_w;
  logic             edge_hit_w;
  logic             prev_vld_w;

  la_trig_regs #(
    .NCH(NCH), .CNT_BYTES(CNT_BYTES), .POS_BYTES(POS_BYTES),
    .CAP_BYTES(CAP_BYTES), .AW(AW)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cap_val(cap_q),
    .lvl_flat(lvl_flat), .edge_kind(edge_kind), .edge_idx(edge_idx),
    .cnt_val(cnt_val), .pos_dont_care(pos_dont_care)
  );

  la_trig_match #(.NCH(NCH)) u_match (
    .clk(clk), .rst_n(rst_n), .arm(arm), .armed(armed_w), .smp_en(smp_en),
    .smp_data(smp_data), .lvl_flat(lvl_flat), .edge_kind(edge_kind),
    .edge_idx(edge_idx), .level_hit(level_hit_w), .edge_hit(edge_hit_w),
    .hit(hit_w), .prev_vld(prev_vld_w)
  );

  la_trig_seq #(.CNTW(CNTW), .CAPW(CAPW)) u_seq (
    .clk(clk), .rst_n(rst_n), .arm(arm), .smp_en(smp_en), .hit(hit_w),
    .cnt_val(cnt_val), .cap_addr(cap_addr), .armed(armed_w),
    .trig_flag(trig_flag), .fire(fire_w), .cap_q(cap_q)
  );

endmodule

// File: rtl/la_trig_chk.sv
module la_trig_chk #(
  parameter int CAPW = 24
) (
  input logic            clk,
  input logic            rst_n,
  input logic            arm,
  input logic            smp_en,
  input logic [CAPW-1:0] cap_addr,
  input logic            trig_flag,
  input logic            fire,
  input logic [CAPW-1:0] cap_q,
  input logic            armed,
  input logic            prev_vld,
  input logic            level_hit,
  input logic            edge_hit,
  input logic [1:0]      edge_kind
);
  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    trig_flag && !arm |=> trig_flag);

  p_arm_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> !trig_flag);

  p_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> trig_flag && (cap_q == $past(cap_addr)));

  p_hold_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    trig_flag && !fire |=> $stable(cap_q));

  p_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> smp_en && armed && !trig_flag && !arm);

  p_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> level_hit);

  p_edge_prev_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fire && (edge_kind != 2'b00) |-> prev_vld && edge_hit);

endmodule

bind la_trig_unit la_trig_chk #(.CAPW(CAPW)) u_chk (
  .clk(clk), .rst_n(rst_n), .arm(arm), .smp_en(smp_en), .cap_addr(cap_addr),
  .trig_flag(trig_flag), .fire(fire_w), .cap_q(cap_q), .armed(armed_w),
  .prev_vld(prev_vld_w), .level_hit(level_hit_w), .edge_hit(edge_hit_w),
  .edge_kind(edge_kind)
);

// File: tb/la_trig_unit_tb.sv
module la_trig_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  cfg_rdata;
  logic        arm = 1'b0;
  logic        smp_en = 1'b0;
  logic [31:0] smp_data = '0;
  logic [23:0] cap_addr = '0;
  logic        trig_flag;
  logic        pos_dont_care;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // bench model
  logic [7:0]  m_reg [9];
  logic [15:0] m_cnt;
  logic [23:0] m_pos;
  bit          m_armed, m_flag, m_pv;
  logic [31:0] m_prev;
  logic [23:0] m_cap;
  int          m_hits;

  always #5 clk = ~clk;

  la_trig_unit u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .arm(arm), .smp_en(smp_en),
    .smp_data(smp_data), .cap_addr(cap_addr), .trig_flag(trig_flag),
    .pos_dont_care(pos_dont_care)
  );

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 9; i++) m_reg[i] = '0;
    m_cnt = 16'd1; m_pos = '0; m_armed = 0; m_flag = 0; m_pv = 0;
    m_prev = '0; m_cap = '0; m_hits = 0;
  endtask

  function automatic bit sample_ok(input logic [31:0] d);
    logic [31:0] need_hi, need_lo;
    logic [1:0]  kind;
    int          ch;
    bit          p, c;
    need_hi = '0; need_lo = '0;
    for (int r = 0; r < 8; r++)
      for (int k = 0; k < 4; k++) begin
        need_hi[r*4+k] = m_reg[r][2*k];
        need_lo[r*4+k] = m_reg[r][2*k+1];
      end
    if ((d & need_hi) != need_hi) return 0;
    if ((~d & need_lo) != need_lo) return 0;
    kind = m_reg[8][7:6];
    ch   = int'(m_reg[8][4:0]);
    if (kind == 2'b00) return 1;
    if (!m_pv) return 0;
    p = m_prev[ch]; c = d[ch];
    if (kind == 2'b01) return !p && c;
    if (kind == 2'b10) return p && !c;
    return p != c;
  endfunction

  task automatic model_step(input bit a, input bit en, input logic [31:0] d, input logic [23:0] ad);
    if (a) begin
      m_armed = 1; m_flag = 0; m_hits = 0; m_pv = 0;
    end else if (en && m_armed) begin
      if (!m_flag && sample_ok(d)) begin
        m_hits++;
        if (m_hits >= ((m_cnt == 0) ? 1 : int'(m_cnt))) begin
          m_flag = 1; m_cap = ad;
        end
      end
      m_prev = d; m_pv = 1;
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
    if (a <= 5'd8) m_reg[a] = d;
    else if (a == 5'h0A) m_cnt[7:0] = d;
    else if (a == 5'h0B) m_cnt[15:8] = d;
    else if (a >= 5'h0C && a <= 5'h0E) m_pos[(a-5'h0C)*8 +: 8] = d;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  task automatic step(input string req, input bit a, input bit en, input logic [31:0] d, input logic [23:0] ad);
    @(negedge clk);
    arm = a; smp_en = en; smp_data = d; cap_addr = ad;
    @(posedge clk);
    #1;
    arm = 0; smp_en = 0;
    model_step(a, en, d, ad);
    chk(req, {31'd0, trig_flag}, {31'd0, m_flag});
  endtask

  task automatic chk_cap(input string req);
    logic [7:0] b0, b1, b2;
    rd(5'h10, b0); rd(5'h11, b1); rd(5'h12, b2);
    chk(req, {8'd0, b2, b1, b0}, {8'd0, m_cap});
  endtask

  task automatic clear_cfg();
    for (int i = 0; i < 9; i++) wr(5'(i), 8'h00);
    wr(5'h0A, 8'h01); wr(5'h0B, 8'h00);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired before the bench finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'h5eed_1234));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R1 reset state
    chk("R1 flag", {31'd0, trig_flag}, 0);
    chk("R1 dont_care", {31'd0, pos_dont_care}, 1);
    rd(5'h0A, v); chk("R1 count lo", {24'd0, v}, 32'h01);
    rd(5'h0B, v); chk("R1 count hi", {24'd0, v}, 0);
    rd(5'h03, v); chk("R1 level reg", {24'd0, v}, 0);
    rd(5'h08, v); chk("R1 edge reg", {24'd0, v}, 0);
    chk_cap("R1 latched address");

    // R8 samples before first arm ignored
    for (int i = 0; i < 4; i++) step("R8 unarmed", 0, 1, 32'hFFFF_FFFF, 24'h100 + 24'(i));
    chk("R8 unarmed flag", {31'd0, trig_flag}, 0);

    // R10 unmapped reads and writes
    wr(5'h09, 8'hAA); wr(5'h0F, 8'h55); wr(5'h10, 8'h77); wr(5'h1F, 8'h66);
    rd(5'h09, v); chk("R10 offset 09", {24'd0, v}, 0);
    rd(5'h0F, v); chk("R10 offset 0F", {24'd0, v}, 0);
    rd(5'h1F, v); chk("R10 offset 1F", {24'd0, v}, 0);
    rd(5'h10, v); chk("R10 capture not writable", {24'd0, v}, 0);

    // R5 count bytes
    wr(5'h0A, 8'h02); wr(5'h0B, 8'h01);
    rd(5'h0A, v); chk("R5 count lo", {24'd0, v}, 32'h02);
    rd(5'h0B, v); chk("R5 count hi", {24'd0, v}, 32'h01);

    // R6 position bytes and don't-care
    wr(5'h0D, 8'h01);
    chk("R6 dont_care nonzero", {31'd0, pos_dont_care}, 0);
    rd(5'h0D, v); chk("R6 pos mid byte", {24'd0, v}, 32'h01);
    wr(5'h0E, 8'h80); wr(5'h0D, 8'h00);
    chk("R6 dont_care top bit", {31'd0, pos_dont_care}, 0);
    wr(5'h0E, 8'h00);
    chk("R6 dont_care zero", {31'd0, pos_dont_care}, 1);

    // R9 unconstrained fires on first sample
    clear_cfg();
    step("R9 arm", 1, 0, 0, 0);
    step("R9 first sample", 0, 1, 32'h1234_5678, 24'hABCDEF);
    chk("R9 flag", {31'd0, trig_flag}, 1);
    chk_cap("R7 capture R9 case");

    // R8 sticky, address held, arm clears
    step("R8 sticky", 0, 1, 32'h0, 24'h111111);
    chk_cap("R8 address held");
    step("R8 arm clears", 1, 1, 32'h0, 24'h222222);
    chk("R8 cleared", {31'd0, trig_flag}, 0);

    // R2 level pattern: ch5 high (reg1 = 0x04), ch30 low (reg7 = 0x20)
    clear_cfg();
    wr(5'h01, 8'h04); wr(5'h07, 8'h20);
    step("R2 arm", 1, 0, 0, 0);
    step("R2 ch30 high", 0, 1, 32'h4000_0020, 24'h10);
    step("R2 ch5 low", 0, 1, 32'h0000_0000, 24'h11);
    step("R2 match", 0, 1, 32'h0000_0020, 24'h12);
    chk("R2 fired", {31'd0, trig_flag}, 1);
    chk_cap("R7 capture R2 case");

    // R2 code 11 never matches
    clear_cfg();
    wr(5'h00, 8'h03);
    step("R2 arm11", 1, 0, 0, 0);
    step("R2 code11 a", 0, 1, 32'h1, 24'h1);
    step("R2 code11 b", 0, 1, 32'h0, 24'h2);
    chk("R2 code11", {31'd0, trig_flag}, 0);

    // R4 count 3 with gaps and smp_en low
    clear_cfg();
    wr(5'h01, 8'h04); wr(5'h0A, 8'h03);
    step("R4 arm", 1, 0, 0, 0);
    step("R4 hit1", 0, 1, 32'h20, 24'h31);
    step("R4 miss", 0, 1, 32'h00, 24'h32);
    step("R4 no enable", 0, 0, 32'h20, 24'h33);
    step("R4 hit2", 0, 1, 32'h20, 24'h34);
    chk("R4 not yet", {31'd0, trig_flag}, 0);
    step("R4 hit3", 0, 1, 32'h20, 24'h35);
    chk("R4 fired on third", {31'd0, trig_flag}, 1);
    chk_cap("R7 capture R4 case");
    wr(5'h0A, 8'h00);
    step("R4 arm0", 1, 0, 0, 0);
    step("R4 count zero", 0, 1, 32'h20, 24'h40);
    chk("R4 count zero fires", {31'd0, trig_flag}, 1);

    // R3 rising edge on channel 9 (edge reg = 0x49)
    clear_cfg();
    wr(5'h08, 8'h49);
    step("R3 arm", 1, 0, 0, 0);
    step("R3 first sample", 0, 1, 32'h200, 24'h50);
    chk("R3 first not edge", {31'd0, trig_flag}, 0);
    step("R3 low", 0, 1, 32'h000, 24'h51);
    step("R3 rise", 0, 1, 32'h200, 24'h52);
    chk("R3 rise fired", {31'd0, trig_flag}, 1);
    chk_cap("R7 capture R3 case");

    // random scenarios against the model
    for (int s = 0; s < 60; s++) begin
      logic [31:0] hi, lo;
      for (int r = 0; r < 8; r++) begin
        logic [7:0] b = '0;
        for (int k = 0; k < 4; k++)
          if ($urandom % 14 == 0) b[2*k +: 2] = ($urandom % 2) ? 2'b01 : 2'b10;
        wr(5'(r), b);
      end
      if ($urandom % 2 == 0) wr(5'h08, {2'(1 + $urandom % 3), 1'b0, 5'($urandom % 32)});
      else wr(5'h08, 8'h00);
      wr(5'h0A, 8'($urandom % 4));
      hi = '0; lo = '0;
      for (int r = 0; r < 8; r++)
        for (int k = 0; k < 4; k++) begin
          hi[r*4+k] = m_reg[r][2*k];
          lo[r*4+k] = m_reg[r][2*k+1];
        end
      step("R4 random arm", 1, 0, 0, 0);
      for (int t = 0; t < 25; t++) begin
        logic [31:0] d = hi | ($urandom & ~lo);
        if ($urandom % 4 == 0) d[$urandom % 32] ^= 1'b1;
        step("R3 R4 random", ($urandom % 40 == 0), ($urandom % 4 != 0), d, 24'($urandom));
      end
      if (m_flag) chk_cap("R7 random capture");
    end

    done = 1;
    summary();
    $finish;
  end

endmodule